// File: doc/BRIEF.md
# Segmented Nonlinear Function Evaluator

This block evaluates one of eleven nonlinear or selection functions on signed fixed-point operands with eight fractional bits in a 16-bit word. Seven of the functions are smooth curves: natural exponential, natural logarithm, square root, hyperbolic tangent, logistic sigmoid, sine and cosine. Each is approximated by a coarse table of sixteen constant segments, one per unit interval of the input over [-8, +8). The other four are exact: absolute value, clip to a window, maximum and minimum. They are computed by comparison and selection.

A caller presents the operands, a four-bit function code and a valid strobe in one cycle. The result is captured in a register and appears on the next clock edge together with a valid flag. The result register keeps its value while no new request arrives. The table contents are computed from the parameters when the design is elaborated, so no table file or external generator is involved.

Top module: `tfu_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.
- R2: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` high. The result for that request is on `out_result` in that same cycle, so the latency is one cycle and requests can arrive back to back.
- R3: When `in_valid` is low, `out_result` keeps its previous value whatever the other inputs do.
- R4: For the table functions, `op_a` is first clamped to [-2048, 2047] (that is, -8.0 to 8.0 - 1/256). The segment number is floor(x) + 8, which equals bits [11:8] of the clamped value plus 0x0800. Every input inside one segment gives the same result, and inputs beyond the range give the result of the end segment.
- R5: The function codes are exp=0, log=1, sqrt=2, tanh=3, sigmoid=4, sin=5 and cos=6. The entry for segment k is f(k - 7.5) scaled by 256, rounded to the nearest integer (halves away from zero) and saturated to [-32768, 32767]. Sigmoid is 1/(1+exp(-x)).
- R6: log at a segment whose midpoint is not positive returns -32768 (0x8000), and sqrt there returns 0.
- R7: Code 7 returns |op_a|. The input -32768 returns 32767.
- R8: Code 8 returns `lo` if `op_a` < `lo`, otherwise `hi` if `op_a` > `hi`, otherwise `op_a`. All comparisons are signed.
- R9: Code 9 returns the signed maximum of `op_a` and `op_b`. Code 10 returns the signed minimum.
- R10: Codes 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| func_sel | input | 4 | Function code |
| op_a | input | 16 | Main operand, signed Q8.8 |
| op_b | input | 16 | Second operand for max and min |
| lo | input | 16 | Lower bound for clip |
| hi | input | 16 | Upper bound for clip |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 16 | Registered signed Q8.8 result |

## Verification
Apart from the table constants, the only state is the valid bit and the result register. A fault in either shows up at the ports on the edge right after the request that caused it: a dropped or extra valid, or a result that changes without a request. A wrong table entry or a wrong segment index appears as a single bad value for one function over one unit-wide interval of input. The bench therefore samples segment edges, out-of-range inputs and both ends of every function, and compares them with an independent model of the midpoint rule. The exact functions are probed at their tie, sign and saturation corners.

// File: rtl/tfu_pkg.sv
package tfu_pkg;

    // Word format
    localparam int DW       = 16;                    // data width
    localparam int FW       = 8;                     // fractional bits
    localparam int SB       = 4;                     // segment index bits
    localparam int SEGS     = 1 << SB;               // segments per table
    localparam int N_TBL    = 7;                     // number of table functions
    localparam int IDX_LO   = FW;
    localparam int IDX_HI   = FW + SB - 1;
    localparam int SAT_MAX  = (1 << (DW - 1)) - 1;
    localparam int SAT_MIN  = -(1 << (DW - 1));
    localparam int CLAMP_HI = (1 << (FW + SB - 1)) - 1;
    localparam int CLAMP_LO = -(1 << (FW + SB - 1));

    typedef logic signed [DW-1:0] q_t;

    typedef enum logic [3:0] {
        FN_EXP  = 4'd0,
        FN_LOG  = 4'd1,
        FN_SQRT = 4'd2,
        FN_TANH = 4'd3,
        FN_SIGM = 4'd4,
        FN_SIN  = 4'd5,
        FN_COS  = 4'd6,
        FN_ABS  = 4'd7,
        FN_CLIP = 4'd8,
        FN_MAX  = 4'd9,
        FN_MIN  = 4'd10
    } fn_e;

    // Value of table fn at the midpoint of segment k, scaled, rounded and saturated
    function automatic q_t tbl_entry(input int fn, input int k);
        real mid;
        real f;
        real r;
        int  ir;
        mid = real'(k - SEGS / 2) + 0.5;
        case (fn)
            0:       f = $exp(mid);
            1:       f = (mid <= 0.0) ? -1.0e9 : $ln(mid);
            2:       f = (mid <= 0.0) ? 0.0 : $sqrt(mid);
            3:       f = $tanh(mid);
            4:       f = 1.0 / (1.0 + $exp(-mid));
            5:       f = $sin(mid);
            6:       f = $cos(mid);
            default: f = 0.0;
        endcase
        r = f * real'(1 << FW);
        if (r > real'(SAT_MAX)) r = real'(SAT_MAX);
        if (r < real'(SAT_MIN)) r = real'(SAT_MIN);
        ir = $rtoi((r >= 0.0) ? (r + 0.5) : (r - 0.5));
        return q_t'(ir);
    endfunction

endpackage

// File: rtl/tfu_seg_index.sv
module tfu_seg_index
    import tfu_pkg::*;
(
    input  q_t            x_i,
    output logic [SB-1:0] idx_o
);
    // Clamp to the covered range, then offset by half the range and keep
    // the integer bits: the offset only flips the top integer bit.
    always_comb begin
        if (x_i > q_t'(CLAMP_HI)) begin
            idx_o = '1;
        end else if (x_i < q_t'(CLAMP_LO)) begin
            idx_o = '0;
        end else begin
            idx_o = {~x_i[IDX_HI], x_i[IDX_HI-1:IDX_LO]};
        end
    end
endmodule

// File: rtl/tfu_table.sv
module tfu_table
    import tfu_pkg::*;
(
    input  logic [3:0]    fn_i,
    input  logic [SB-1:0] idx_i,
    output q_t            val_o
);
    q_t rom [N_TBL][SEGS];

    // Constant rows, one per table function
    for (genvar gf = 0; gf < N_TBL; gf++) begin : g_fn
        for (genvar gk = 0; gk < SEGS; gk++) begin : g_seg
            assign rom[gf][gk] = tbl_entry(gf, gk);
        end
    end

    always_comb begin
        val_o = '0;
        for (int f = 0; f < N_TBL; f++) begin
            if (int'(fn_i) == f) begin
                val_o = rom[f][idx_i];
            end
        end
    end
endmodule

// File: rtl/tfu_exact.sv
module tfu_exact
    import tfu_pkg::*;
(
    input  logic [3:0] fn_i,
    input  q_t         a_i,
    input  q_t         b_i,
    input  q_t         lo_i,
    input  q_t         hi_i,
    output q_t         val_o
);
    always_comb begin
        case (fn_i)
            FN_ABS: begin
                if (a_i == q_t'(SAT_MIN)) begin
                    val_o = q_t'(SAT_MAX);
                end else if (a_i < 0) begin
                    val_o = -a_i;
                end else begin
                    val_o = a_i;
                end
            end
            FN_CLIP: begin
                if (a_i < lo_i) begin
                    val_o = lo_i;
                end else if (a_i > hi_i) begin
                    val_o = hi_i;
                end else begin
                    val_o = a_i;
                end
            end
            FN_MAX:  val_o = (a_i >= b_i) ? a_i : b_i;
            FN_MIN:  val_o = (a_i <= b_i) ? a_i : b_i;
            default: val_o = '0;
        endcase
    end
endmodule

// File: rtl/tfu_top.sv
module tfu_top
    import tfu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    func_sel,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic          out_valid,
    output logic [DW-1:0] out_result
);
    typedef struct packed {
        logic vld;
        q_t   res;
    } st_t;

    st_t           st_d, st_q;
    logic [SB-1:0] seg_idx;
    q_t            tbl_val;
    q_t            exact_val;

    tfu_seg_index i_index (
        .x_i   (q_t'(op_a)),
        .idx_o (seg_idx)
    );

    tfu_table i_table (
        .fn_i  (func_sel),
        .idx_i (seg_idx),
        .val_o (tbl_val)
    );

    tfu_exact i_exact (
        .fn_i  (func_sel),
        .a_i   (q_t'(op_a)),
        .b_i   (q_t'(op_b)),
        .lo_i  (q_t'(lo)),
        .hi_i  (q_t'(hi)),
        .val_o (exact_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = (int'(func_sel) < N_TBL) ? tbl_val : exact_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/tfu_chk.sv
module tfu_chk
    import tfu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    func_sel,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [DW-1:0] lo,
    input logic [DW-1:0] hi,
    input logic          out_valid,
    input logic [DW-1:0] out_result
);
    q_t sa, sb, slo, shi, sres;
    assign sa   = q_t'(op_a);
    assign sb   = q_t'(op_b);
    assign slo  = q_t'(lo);
    assign shi  = q_t'(hi);
    assign sres = q_t'(out_result);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R3
    AST_SQRT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_SQRT) |=> !out_result[DW-1]); // R6
    AST_LOG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_LOG && sa < 0) |=> sres == q_t'(SAT_MIN)); // R6
    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_ABS) |=> !out_result[DW-1]); // R7
    AST_CLIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_CLIP && slo <= shi)
        |=> (sres >= $past(slo) && sres <= $past(shi))); // R8
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_MAX)
        |=> (sres >= $past(sa) && sres >= $past(sb)
             && (sres == $past(sa) || sres == $past(sb)))); // R9
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == FN_MIN)
        |=> (sres <= $past(sa) && sres <= $past(sb)
             && (sres == $past(sa) || sres == $past(sb)))); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel > 4'd10) |=> out_result == '0); // R10
endmodule

bind tfu_top tfu_chk i_tfu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .func_sel   (func_sel),
    .op_a       (op_a),
    .op_b       (op_b),
    .lo         (lo),
    .hi         (hi),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_tfu_top.sv
`timescale 1ns/1ps
module test_tfu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  func_sel = '0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [15:0] lo = '0;
    logic [15:0] hi = '0;
    logic        out_valid;
    logic [15:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tfu_top i_tfu_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .func_sel   (func_sel),
        .op_a       (op_a),
        .op_b       (op_b),
        .lo         (lo),
        .hi         (hi),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    typedef struct packed {
        logic [3:0]  sel;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] l;
        logic [15:0] h;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0000, 16'h0000, 16'h0000, 16'h0000},  // exp seg 8
        '{4'd0,  16'h0100, 16'h0000, 16'h0000, 16'h0000},  // exp segment start
        '{4'd0,  16'h01FF, 16'h0000, 16'h0000, 16'h0000},  // exp segment end
        '{4'd0,  16'h07FF, 16'h0000, 16'h0000, 16'h0000},  // exp saturates
        '{4'd0,  16'h7FFF, 16'h0000, 16'h0000, 16'h0000},  // above range
        '{4'd0,  16'h8000, 16'h0000, 16'h0000, 16'h0000},  // below range
        '{4'd0,  16'hF800, 16'h0000, 16'h0000, 16'h0000},  // -8.0 exactly
        '{4'd1,  16'h0100, 16'h0000, 16'h0000, 16'h0000},  // log 1.5
        '{4'd1,  16'h0600, 16'h0000, 16'h0000, 16'h0000},  // log 6.5
        '{4'd1,  16'hFF00, 16'h0000, 16'h0000, 16'h0000},  // log negative
        '{4'd2,  16'h0400, 16'h0000, 16'h0000, 16'h0000},  // sqrt 4.5
        '{4'd2,  16'hFF00, 16'h0000, 16'h0000, 16'h0000},  // sqrt negative
        '{4'd3,  16'h00FF, 16'h0000, 16'h0000, 16'h0000},  // tanh +
        '{4'd3,  16'hFFFF, 16'h0000, 16'h0000, 16'h0000},  // tanh just below 0
        '{4'd4,  16'h0000, 16'h0000, 16'h0000, 16'h0000},  // sigmoid
        '{4'd4,  16'hFD80, 16'h0000, 16'h0000, 16'h0000},  // sigmoid negative
        '{4'd5,  16'h0180, 16'h0000, 16'h0000, 16'h0000},  // sin
        '{4'd5,  16'hFC00, 16'h0000, 16'h0000, 16'h0000},  // sin negative
        '{4'd6,  16'hFD00, 16'h0000, 16'h0000, 16'h0000},  // cos
        '{4'd6,  16'h0300, 16'h0000, 16'h0000, 16'h0000},  // cos positive
        '{4'd7,  16'h8000, 16'h0000, 16'h0000, 16'h0000},  // abs saturates
        '{4'd7,  16'hFFFB, 16'h0000, 16'h0000, 16'h0000},  // abs -5
        '{4'd7,  16'h012C, 16'h0000, 16'h0000, 16'h0000},  // abs 300
        '{4'd8,  16'h01F4, 16'h0000, 16'hFF00, 16'h0100},  // clip high
        '{4'd8,  16'hFC18, 16'h0000, 16'hFF00, 16'h0100},  // clip low
        '{4'd8,  16'h0064, 16'h0000, 16'hFF00, 16'h0100},  // clip pass
        '{4'd9,  16'hFFFD, 16'h0007, 16'h0000, 16'h0000},  // max
        '{4'd9,  16'h8000, 16'h7FFF, 16'h0000, 16'h0000},  // max extremes
        '{4'd10, 16'hFFFD, 16'h0007, 16'h0000, 16'h0000},  // min
        '{4'd10, 16'h0042, 16'h0042, 16'h0000, 16'h0000},  // min tie
        '{4'd11, 16'h1234, 16'h0000, 16'h0000, 16'h0000},  // reserved
        '{4'd15, 16'h8000, 16'h0000, 16'h0000, 16'h0000}   // reserved
    };

    // Independent model of the requirements
    function automatic int model(input logic [3:0] sel, input logic [15:0] a,
                                 input logic [15:0] b, input logic [15:0] l,
                                 input logic [15:0] h);
        int ai, bi, li, hv, ac, seg, res;
        real m, f, r;
        ai = int'($signed(a));
        bi = int'($signed(b));
        li = int'($signed(l));
        hv = int'($signed(h));
        res = 0;
        if (sel < 4'd7) begin
            ac = (ai > 2047) ? 2047 : ((ai < -2048) ? -2048 : ai);
            seg = (ac >>> 8) + 8;
            m = real'(seg) - 7.5;
            case (sel)
                4'd0:    f = $exp(m);
                4'd1:    f = (m > 0.0) ? $ln(m) : -1000.0;
                4'd2:    f = (m > 0.0) ? $sqrt(m) : 0.0;
                4'd3:    f = $tanh(m);
                4'd4:    f = 1.0 / (1.0 + $exp(-m));
                4'd5:    f = $sin(m);
                default: f = $cos(m);
            endcase
            r = f * 256.0;
            if (r > 32767.0) r = 32767.0;
            if (r < -32768.0) r = -32768.0;
            res = $rtoi((r >= 0.0) ? (r + 0.5) : (r - 0.5));
        end else if (sel == 4'd7) begin
            res = (ai == -32768) ? 32767 : ((ai < 0) ? -ai : ai);
        end else if (sel == 4'd8) begin
            res = (ai < li) ? li : ((ai > hv) ? hv : ai);
        end else if (sel == 4'd9) begin
            res = (ai >= bi) ? ai : bi;
        end else if (sel == 4'd10) begin
            res = (ai <= bi) ? ai : bi;
        end
        return res;
    endfunction

    function automatic string tag_for(input logic [3:0] sel, input logic [15:0] a);
        int ai;
        ai = int'($signed(a));
        if (sel < 4'd7) begin
            if (ai > 2047 || ai < -2048) return "R4";
            if ((sel == 4'd1 || sel == 4'd2) && ai < 0) return "R6";
            return "R5";
        end
        if (sel == 4'd7) return "R7";
        if (sel == 4'd8) return "R8";
        if (sel == 4'd9 || sel == 4'd10) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        func_sel = v.sel;
        op_a     = v.a;
        op_b     = v.b;
        lo       = v.l;
        hi       = v.h;
        @(posedge clk);
        #1;
    endtask

    int seg_lo_res;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_result), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        // Vector table, back to back: each result one edge after its request
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i]);
            check("R2", int'(out_valid), 1);
            check(tag_for(VECS[i].sel, VECS[i].a), int'($signed(out_result)),
                  model(VECS[i].sel, VECS[i].a, VECS[i].b, VECS[i].l, VECS[i].h));
        end

        // R4: constant across a segment, change at the next
        issue('{4'd3, 16'h0200, 16'h0, 16'h0, 16'h0});
        seg_lo_res = int'($signed(out_result));
        issue('{4'd3, 16'h02FF, 16'h0, 16'h0, 16'h0});
        check("R4", int'($signed(out_result)), seg_lo_res);
        issue('{4'd3, 16'h0300, 16'h0, 16'h0, 16'h0});
        check("R4", int'(int'($signed(out_result)) != seg_lo_res), 1);

        // R3: hold while no request, with the operands moving
        issue('{4'd7, 16'hFF80, 16'h0, 16'h0, 16'h0});
        check("R7", int'($signed(out_result)), 128);
        @(negedge clk);
        in_valid = 1'b0;
        func_sel = 4'd0;
        op_a     = 16'h0400;
        @(posedge clk);
        #1;
        check("R2", int'(out_valid), 0);
        check("R3", int'($signed(out_result)), 128);
        @(negedge clk);
        func_sel = 4'd9;
        op_b     = 16'h7000;
        @(posedge clk);
        #1;
        check("R3", int'($signed(out_result)), 128);

        // R8: lo wins when the window is inverted
        issue('{4'd8, 16'h0000, 16'h0, 16'h0200, 16'h0100});
        check("R8", int'($signed(out_result)), 512);

        // R1: reset in mid-run clears state
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_result), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule